// File: doc/BRIEF.md
# One-Shot Programmable Down-Count Timer

This block is an 8-bit interval timer that runs once for each load. Software writes a preset value, and the counter starts to step down from that value. Each step happens on one tick of a count clock. When the count goes below zero, the timer raises a one-cycle interrupt request. It then stops and stays idle until it is loaded again. There is no automatic reload. The time from load to request is therefore (preset + 1) ticks.

The count clock comes from the system clock through an internal two-stage prescaler. With a 3 MHz master clock, the first stage divides by 94 and gives roughly 32 kHz. The second stage divides that by a further 1000 and gives roughly 32 Hz. A rate-select input chooses which of the two tick streams drives the counter. The interrupt-enable input gates only the request. The counter still halts at underflow when the request is disabled.

Top module: `oneshot_tick_timer`

## Requirements
- R1: After reset, `active` is 0 and `irq_req` is 0.
- R2: A cycle with `load_stb` high loads `load_val`, and `active` is 1 from the next cycle on.
- R3: With `rate_sel` = 1 (fast rate), the request rises FAST_DIV*(preset+1) clock cycles after the edge that sampled the load.
- R4: With `rate_sel` = 0 (slow rate, the reset-safe choice), the request rises FAST_DIV*SLOW_DIV*(preset+1) clock cycles after the load edge.
- R5: `irq_req` is a single-cycle pulse. It is high in exactly the cycle in which `active` first reads 0 after an underflow, and never at any other time.
- R6: After underflow the timer stays idle. No further request appears and `active` stays 0 until the next load.
- R7: With `irq_en` = 0, no request is raised, but `active` still falls in the same cycle it would have fallen with the request enabled.
- R8: A load while the timer is running restarts the count from the new value and clears the prescaler phase. The earlier count then produces no request.
- R9: Preset 00h gives an interval of one tick, and preset FFh gives an interval of 256 ticks.
- R10: A load in the same cycle as the final, underflowing tick takes priority. No request is raised and `active` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_stb | input | 1 | One-cycle strobe that loads the preset and starts counting |
| load_val | input | CNT_W | Preset value taken on the strobe |
| rate_sel | input | 1 | Tick rate: 1 is the fast rate, 0 is the slow rate |
| irq_en | input | 1 | Enables the interrupt request |
| irq_req | output | 1 | One-cycle interrupt request on underflow |
| active | output | 1 | High from load until underflow |

## Verification
The bench builds the timer with FAST_DIV = 4 and SLOW_DIV = 3. This makes one fast tick 4 cycles and one slow tick 12 cycles. At these values a full-range preset of FFh completes in about a thousand cycles. A restart seven cycles into a run leaves a prescaler phase of 3, which does not divide into 4. Any leftover phase would therefore shift the measured interval by a visible amount. The same small divisors let the bench place a reload exactly on the underflowing tick, and they keep the slow path fully exercised within a short run.

// File: rtl/ostimer_pkg.sv
package ostimer_pkg;

  // Width of a divider stage counter for a given division ratio
  function automatic int stage_width(input int div);
    return (div > 1) ? $clog2(div) : 1;
  endfunction

  // Clock cycles from load edge to underflow edge for a preset and tick length
  function automatic int interval_cycles(input int preset, input int tick_len);
    return tick_len * (preset + 1);
  endfunction

  // True when the given count is about to wrap below zero
  function automatic logic at_floor(input logic [7:0] cnt);
    return (cnt == 8'h00);
  endfunction

endpackage

// File: rtl/ostimer_prescaler.sv
module ostimer_prescaler #(
  parameter int FAST_DIV = 94,
  parameter int SLOW_DIV = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic rate_fast,
  output logic tick
);
  import ostimer_pkg::*;

  localparam int FW = stage_width(FAST_DIV);
  localparam int SW = stage_width(SLOW_DIV);
  localparam logic [FW-1:0] FAST_LAST = FW'(FAST_DIV - 1);

  logic [FW-1:0] fast_cnt;
  logic          fast_tick;
  logic          slow_tick;

  // First stage: fast tick stream
  assign fast_tick = run && (fast_cnt == FAST_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   fast_cnt <= '0;
    else if (!run || restart)     fast_cnt <= '0;
    else if (fast_cnt == FAST_LAST) fast_cnt <= '0;
    else                          fast_cnt <= fast_cnt + 1'b1;
  end

  // R3: the fast-stage phase never leaves its range
  assert_fast_phase_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fast_cnt <= FAST_LAST);

  // Second stage: slow tick stream, present only when it divides
  generate
    if (SLOW_DIV > 1) begin : g_slow_stage
      localparam logic [SW-1:0] SLOW_LAST = SW'(SLOW_DIV - 1);
      logic [SW-1:0] slow_cnt;

      assign slow_tick = fast_tick && (slow_cnt == SLOW_LAST);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 slow_cnt <= '0;
        else if (!run || restart)   slow_cnt <= '0;
        else if (fast_tick) begin
          if (slow_cnt == SLOW_LAST) slow_cnt <= '0;
          else                       slow_cnt <= slow_cnt + 1'b1;
        end
      end

      // R4: slow ticks only coincide with fast ticks
      assert_slow_on_fast_R4: assert property (@(posedge clk) disable iff (!rst_n)
        slow_tick |-> fast_tick);
    end else begin : g_slow_bypass
      assign slow_tick = fast_tick;
    end
  endgenerate

  assign tick = rate_fast ? fast_tick : slow_tick;

  // R6: no tick reaches the counter while the timer is idle
  assert_no_tick_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick);

endmodule

// File: rtl/ostimer_counter.sv
module ostimer_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_stb,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             active,
  output logic             underflow
);
  import ostimer_pkg::*;

  logic [CNT_W-1:0] cnt;
  logic             floor_hit;

  assign floor_hit = (cnt == '0);
  // Underflow event: the step from zero to all-ones, unless a load takes priority
  assign underflow = active && tick && floor_hit && !load_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (load_stb) begin
      cnt    <= load_val;
      active <= 1'b1;
    end else if (active && tick) begin
      cnt <= cnt - 1'b1;
      if (floor_hit) active <= 1'b0;
    end
  end

  // R2: a load always leaves the timer running
  assert_load_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> active);

  // R6: after underflow the timer is idle and stays so without a load
  assert_halt_after_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> !active);

  assert_idle_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !load_stb) |=> !active);

  // R6: counter value is frozen while idle
  assert_count_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !load_stb) |=> $stable(cnt));

endmodule

// File: rtl/ostimer_irq.sv
module ostimer_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic underflow,
  input  logic irq_en,
  input  logic active,
  output logic irq_req
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_req <= 1'b0;
    else        irq_req <= underflow && irq_en;
  end

  // R5: request is a single-cycle pulse
  assert_irq_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> !irq_req);

  // R5: request only appears as the timer stops
  assert_irq_with_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (!active && $fell(active)));

  // R7: a request needs the enable in the underflow cycle
  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> $past(irq_en));

endmodule

// File: rtl/oneshot_tick_timer.sv
module oneshot_tick_timer #(
  parameter int FAST_DIV = 94,
  parameter int SLOW_DIV = 1000,
  parameter int CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_stb,
  input  logic [CNT_W-1:0] load_val,
  input  logic             rate_sel,
  input  logic             irq_en,
  output logic             irq_req,
  output logic             active
);

  logic tick;
  logic underflow;

  ostimer_prescaler #(
    .FAST_DIV (FAST_DIV),
    .SLOW_DIV (SLOW_DIV)
  ) u_prescaler (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (active),
    .restart   (load_stb),
    .rate_fast (rate_sel),
    .tick      (tick)
  );

  ostimer_counter #(
    .CNT_W (CNT_W)
  ) u_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_stb  (load_stb),
    .load_val  (load_val),
    .tick      (tick),
    .active    (active),
    .underflow (underflow)
  );

  ostimer_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .underflow (underflow),
    .irq_en    (irq_en),
    .active    (active),
    .irq_req   (irq_req)
  );

  // R10: a load on the underflowing tick keeps the timer running, no request
  assert_load_beats_floor_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> (active && !irq_req));

endmodule

// File: tb/tb_oneshot_tick_timer.sv
module tb_oneshot_tick_timer;
  localparam int F = 4;
  localparam int S = 3;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       load_stb = 0;
  logic [7:0] load_val = 0;
  logic       rate_sel = 0;
  logic       irq_en = 1;
  logic       irq_req;
  logic       active;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  int expq[$];

  oneshot_tick_timer #(.FAST_DIV(F), .SLOW_DIV(S), .CNT_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .load_stb(load_stb), .load_val(load_val),
    .rate_sel(rate_sel), .irq_en(irq_en), .irq_req(irq_req), .active(active));

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Monitor: compares observed requests against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (expq.size() > 0 && cyc > expq[0]) begin
        check(0, "R5 missed request", cyc, expq[0]);
        void'(expq.pop_front());
      end
      if (irq_req) begin
        if (expq.size() == 0) check(0, "R5 unexpected request", cyc, -1);
        else begin
          check(cyc == expq[0], "R3/R4 request cycle", cyc, expq[0]);
          void'(expq.pop_front());
        end
      end
    end
  end

  // Driver: call at a negedge; returns the cycle in which the request is due
  task automatic do_load(input int val, input bit fast, output int due);
    int tl;
    tl = fast ? F : F * S;
    load_val = 8'(val);
    rate_sel = fast;
    load_stb = 1;
    due = cyc + 1 + tl * (val + 1);
    @(negedge clk);
    load_stb = 0;
    check(active == 1, "R2 active after load", active, 1);
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic run_one(input int val, input bit fast, input bit en, input string req);
    int due;
    irq_en = en;
    do_load(val, fast, due);
    if (en) expq.push_back(due);
    wait_until(due - 1);
    check(active == 1, req, active, 1);
    @(negedge clk);
    check(active == 0, req, active, 0);
    check(irq_req == en, {req, " R5 pulse"}, irq_req, en);
    @(negedge clk);
    check(irq_req == 0, "R5 single cycle", irq_req, 0);
  endtask

  initial begin
    int due1;
    int due2;
    fork
      begin
        repeat (3) @(negedge clk);
        check(active == 0, "R1 reset active", active, 0);
        check(irq_req == 0, "R1 reset irq", irq_req, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        check(active == 0, "R1 idle after reset", active, 0);

        run_one(5, 1, 1, "R3 fast preset 5");
        run_one(2, 0, 1, "R4 slow preset 2");
        run_one(0, 1, 1, "R9 preset 00h");
        run_one(255, 1, 1, "R9 preset FFh");
        run_one(1, 0, 1, "R4 slow preset 1");

        // R6: stays idle with no further request
        repeat (100) @(negedge clk);
        check(active == 0, "R6 no reload", active, 0);

        // R7: disabled request, stop timing unchanged
        run_one(3, 1, 0, "R7 disabled irq");
        repeat (50) @(negedge clk);
        check(active == 0, "R7 idle after stop", active, 0);

        // R8: reload mid-run restarts count and prescaler phase
        irq_en = 1;
        do_load(10, 1, due1);
        repeat (6) @(negedge clk);
        do_load(2, 1, due2);
        expq.push_back(due2);
        wait_until(due2 - 1);
        check(active == 1, "R8 running before new due", active, 1);
        @(negedge clk);
        check(active == 0, "R8 stop at new due", active, 0);
        wait_until(due1 + 5);
        check(active == 0, "R8 old count discarded", active, 0);

        // R10: load on the underflowing tick wins
        do_load(1, 1, due1);
        wait_until(due1 - 1);
        do_load(3, 1, due2);
        check(active == 1 && irq_req == 0, "R10 load beats floor", active, 1);
        expq.push_back(due2);
        wait_until(due2 + 3);
        check(active == 0, "R10 later stop", active, 0);

        repeat (10) @(negedge clk);
        check(expq.size() == 0, "R5 all requests seen", expq.size(), 0);
      end
      begin
        repeat (150000) @(negedge clk);
        check(0, "watchdog", cyc, 150000);
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule